// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides an unsigned dividend by an unsigned, nonzero divisor. It handles one quotient bit per clock cycle. A start pulse loads both operands. The block then runs one add-or-subtract step per cycle through a single shared adder. It reports the quotient, the remainder and a done flag that stays high until the next accepted start.

The partial remainder is kept in two's complement form: a magnitude register and a one-bit sign register. Each step feeds the adder with the partial remainder shifted left by one, with the next dividend bit entering at the bottom. The stored sign of the previous step chooses the operation:

- If the sign was non-negative, the divisor is subtracted.
- If the sign was negative, the divisor is added.

Because the partial remainder starts at zero, the first step always subtracts. The inverted sign of each result is shifted into the quotient. If the last result is negative, one extra cycle adds the divisor back so that the reported remainder is correct.

Top module: `nr_divider`

## Requirements
- R1: While rst_ni is low, and after reset is released until the first start, done_o, quotient_o and remainder_o are all 0.
- R2: A start_i seen high at a clock edge while the block is idle or done captures dividend_i and divisor_i. done_o is low from the next edge on, until the result of that operation is ready.
- R3: For every nonzero divisor D and every dividend N, quotient_o equals floor(N / D) when done_o is high.
- R4: When done_o is high, remainder_o equals N mod D, and is therefore below D.
- R5: Counting the edge that captures start as edge 1, done_o goes high after edge 9 when the quotient is odd. It goes high after edge 10 when the quotient is even, because the last partial remainder is then negative and costs one correction cycle.
- R6: A start_i pulse that arrives while an operation is in progress is ignored. The result and latency are those of the operands first captured.
- R7: While done_o is high and start_i is low, changes on dividend_i and divisor_i have no effect. done_o, quotient_o and remainder_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled at the clock edge |
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor, must be nonzero |
| quotient_o | output | W | Quotient, valid while done_o is high |
| remainder_o | output | W | Remainder, valid while done_o is high |
| done_o | output | 1 | Result valid; held until the next accepted start |

## Verification
The main function runs over every divisor from 1 to 255 against a dividend sweep. The sweep includes 0, 255 and operand pairs where N is below, equal to or a multiple of D. Each of these patterns gives a different quotient parity, which decides whether the correction cycle runs and therefore the expected latency.

Two further cases check the extremes of the adder range. Dividing 255 by 1 drives the shifted window to its widest positive value. Dividing 254 by 255 keeps every step negative after the first one.

Separate scenarios cover the edge conditions:
- a second start pulse in the middle of an operation, which must not disturb the result or the latency;
- operand changes after completion, which must not disturb the held outputs.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2,
    ST_DONE = 2'd3
  } div_state_e;
endpackage

// File: rtl/nr_div_addsub.sv
module nr_div_addsub #(
  parameter int unsigned AW    = 10,
  parameter int unsigned SPLIT = 5
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  input  logic          sub_i,
  output logic [AW-1:0] sum_o
);
  logic [AW-1:0] b_x;
  assign b_x = b_i ^ {AW{sub_i}};

  generate
    if (SPLIT == 0 || SPLIT >= AW) begin : g_ripple
      assign sum_o = a_i + b_x + {{(AW-1){1'b0}}, sub_i};
    end else begin : g_csel
      localparam int unsigned LO = SPLIT;
      localparam int unsigned HI = AW - SPLIT;
      logic [LO:0]   lo_sum;
      logic [HI-1:0] hi_c0, hi_c1;
      assign lo_sum = {1'b0, a_i[LO-1:0]} + {1'b0, b_x[LO-1:0]} + {{LO{1'b0}}, sub_i};
      // both upper sums precomputed, low carry selects
      assign hi_c0  = a_i[AW-1:LO] + b_x[AW-1:LO];
      assign hi_c1  = a_i[AW-1:LO] + b_x[AW-1:LO] + {{(HI-1){1'b0}}, 1'b1};
      assign sum_o  = {(lo_sum[LO] ? hi_c1 : hi_c0), lo_sum[LO-1:0]};
    end
  endgenerate
endmodule

// File: rtl/nr_div_ctrl.sv
module nr_div_ctrl
  import nr_div_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic neg_i,
  output logic load_o,
  output logic iter_o,
  output logic fix_o,
  output logic done_o
);
  div_state_e     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           last;

  assign last   = (cnt_q == CW'(W - 1));
  assign load_o = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign iter_o = (state_q == ST_ITER);
  assign fix_o  = (state_q == ST_FIX);
  assign done_o = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i) begin
        state_d = ST_ITER;
        cnt_d   = '0;
      end
      ST_ITER: begin
        cnt_d = cnt_q + CW'(1);
        if (last) state_d = neg_i ? ST_FIX : ST_DONE;
      end
      ST_FIX:  state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  a_r3_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_o |-> (cnt_q < CW'(W)));
  a_r5_done_after_work: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(iter_o || fix_o));
  a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  a_r6_busy_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iter_o || fix_o) |=> !done_o || $past(last || fix_o));
endmodule

// File: rtl/nr_div_datapath.sv
module nr_div_datapath #(
  parameter int unsigned W     = 8,
  parameter int unsigned SPLIT = 5,
  localparam int unsigned AW   = W + 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         iter_i,
  input  logic         fix_i,
  input  logic         done_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         neg_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  logic [W-1:0]  quo_q, dvd_q, dvs_q, rem_q;
  logic          sgn_q;
  logic [AW-1:0] op_a, op_b, res;
  logic          op_sub;

  // shifted window {sign, rem, next dividend bit}; correction uses unshifted sign-extended remainder
  assign op_a   = fix_i ? {sgn_q, sgn_q, rem_q} : {sgn_q, rem_q, dvd_q[W-1]};
  assign op_b   = {2'b00, dvs_q};
  assign op_sub = iter_i && !sgn_q;

  nr_div_addsub #(.AW(AW), .SPLIT(SPLIT)) i_addsub (
    .a_i   (op_a),
    .b_i   (op_b),
    .sub_i (op_sub),
    .sum_o (res)
  );

  assign neg_o = res[W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q <= '0;
      dvd_q <= '0;
      dvs_q <= '0;
      rem_q <= '0;
      sgn_q <= 1'b0;
    end else if (load_i) begin
      quo_q <= '0;
      dvd_q <= dividend_i;
      dvs_q <= divisor_i;
      rem_q <= '0;
      sgn_q <= 1'b0;
    end else if (iter_i) begin
      rem_q <= res[W-1:0];
      sgn_q <= res[W];
      dvd_q <= {dvd_q[W-2:0], 1'b0};
      quo_q <= {quo_q[W-2:0], ~res[W]};
    end else if (fix_i) begin
      rem_q <= res[W-1:0];
      sgn_q <= res[W];
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  a_r5_fix_only_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_i |-> sgn_q);
  a_r4_rem_below_divisor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!sgn_q && rem_q < dvs_q));
  a_r6_divisor_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(dvs_q));
  a_r3_first_step_subtracts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (iter_i && !sgn_q));
endmodule

// File: rtl/nr_divider.sv
module nr_divider #(
  parameter int unsigned W     = 8,
  parameter int unsigned SPLIT = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quotient_o,
  output logic [W-1:0] remainder_o,
  output logic         done_o
);
  logic load, iter, fix, neg;

  nr_div_ctrl #(.W(W)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .neg_i   (neg),
    .load_o  (load),
    .iter_o  (iter),
    .fix_o   (fix),
    .done_o  (done_o)
  );

  nr_div_datapath #(.W(W), .SPLIT(SPLIT)) i_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .iter_i     (iter),
    .fix_i      (fix),
    .done_i     (done_o),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .neg_o      (neg),
    .quo_o      (quotient_o),
    .rem_o      (remainder_o)
  );

  a_r2_start_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && done_o) |=> !done_o);
  a_r7_outputs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o)));
endmodule

// File: tb/test_nr_divider.sv
module test_nr_divider;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic [W-1:0] quo, rem;
  logic         done;

  int unsigned n_tests = 0, n_fail = 0, cycles = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  nr_divider #(.W(W)) i_nr_divider (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .dividend_i  (dvd),
    .divisor_i   (dvs),
    .quotient_o  (quo),
    .remainder_o (rem),
    .done_o      (done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: act cycles=%0d exp below 190000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // start at a negedge; returns edges until done (start edge = 1)
  task automatic launch(input int n, input int d, output int lat);
    dvd = W'(n); dvs = W'(d); start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(posedge clk); @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_run(input int n, input int d);
    int lat;
    launch(n, d, lat);
    check("R3 quotient", int'(quo), n / d);
    check("R4 remainder", int'(rem), n % d);
    check("R5 latency", lat, ((n / d) % 2 == 1) ? 9 : 10);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 done", int'(done), 0);
    check("R1 quotient", int'(quo), 0);
    check("R1 remainder", int'(rem), 0);
  endtask

  task automatic t_corners();
    t_run(255, 1);
    t_run(254, 255);
    t_run(0, 5);
    t_run(5, 5);
    t_run(7, 255);
    t_run(255, 255);
    t_run(200, 3);
  endtask

  task automatic t_start_clears();
    dvd = 8'd9; dvs = 8'd2; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check("R2 done low after start", int'(done), 0);
    while (!done) @(negedge clk);
    check("R2 new operands captured", int'(quo), 4);
  endtask

  task automatic t_busy_start();
    int lat;
    dvd = 8'd100; dvs = 8'd7; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (3) begin @(posedge clk); @(negedge clk); lat++; end
    dvd = 8'd250; dvs = 8'd3; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0; lat++;
    while (!done && lat < 40) begin @(posedge clk); @(negedge clk); lat++; end
    check("R6 quotient kept", int'(quo), 14);
    check("R6 remainder kept", int'(rem), 2);
    check("R6 latency kept", lat, 10);
  endtask

  task automatic t_hold();
    int q0, r0;
    t_run(77, 6);
    q0 = int'(quo); r0 = int'(rem);
    dvd = 8'd3; dvs = 8'd1;
    repeat (5) @(negedge clk);
    check("R7 done held", int'(done), 1);
    check("R7 quotient held", int'(quo), q0);
    check("R7 remainder held", int'(rem), r0);
  endtask

  task automatic t_sweep();
    for (int d = 1; d < 256; d++) begin
      for (int n = 0; n < 256; n += 37) t_run(n, d);
      t_run(255, d);
      t_run(d, d);
    end
  endtask

  initial begin
    t_reset();
    t_corners();
    t_start_clears();
    t_busy_start();
    t_hold();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule